// File: doc/BRIEF.md
# Processing-Unit Operand Register File with Address-Aligned Indexing

This block holds the operands of one 16-lane FP16 processing unit sitting beside a memory bank. It has two vector register halves (an A half and a B half) of 256-bit entries, each entry the size of one memory burst. It also has two scalar halves of 16-bit entries: one holds addends and the other holds multiplicands. Two read ports return 256-bit vectors. A scalar read comes back copied into all sixteen lanes, so the datapath can treat it like any other vector operand. One write port stores a vector, or lane 0 of it for a scalar half. On request it clamps every negative lane to zero on the way in.

When aligned mode is on, the vector-half indices are not taken from the instruction fields. They are computed from the column address bits of the memory access that triggers the instruction, and for the B half from the low row bit as well. A memory controller that reorders accesses therefore cannot separate a bank address from the register it belongs to. A looped multiply-accumulate whose column address steps by one walks through all eight A entries in turn.

The read outputs are registered. A write takes effect at the clock edge. A read of the same entry in that cycle returns the older contents.

Top module: `pim_operand_rf`

## Requirements
- R1: While `rst` is high at a clock edge, every entry of all four halves is cleared to zero and both read outputs become zero.
- R2: The select code picks the half: 0 is vector A, 1 is vector B, 2 is scalar add, 3 is scalar multiply. Each half has 8 entries, and a value written to one entry of one half reads back unchanged and disturbs no other entry.
- R3: A read enabled at a clock edge presents its data on the read output after that edge. While the port's enable is low, the output holds its last value even if the entry is overwritten.
- R4: A write is visible to any read issued at a later edge. A read of the same entry at the same edge returns the value held before the write.
- R5: A write to a scalar half stores bits [15:0] of the write data. A read of a scalar half returns that 16-bit value in every one of the 16 lanes.
- R6: With `wr_relu` high, every lane whose bit 15 is 1 (negative zero included) is stored as 16'h0000 and every other lane is stored unchanged. With `wr_relu` low, all lanes are stored unchanged.
- R7: With `aligned` high, an access to vector A uses `col_addr[2:0]` as the entry index and ignores the instruction index.
- R8: With `aligned` high, an access to vector B uses `{row_addr_lsb, col_addr[4:3]}` as the entry index and ignores the instruction index.
- R9: Scalar halves always use the instruction index. With `aligned` low, every half uses the instruction index, and the row and column inputs have no effect.
- R10: Lane i of every 256-bit vector occupies bits [16*i+15:16*i].
- R11: The two read ports work independently and may read different halves and entries at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aligned | input | 1 | Take vector-half indices from the access address |
| row_addr_lsb | input | 1 | Bit 0 of the triggering access's row address |
| col_addr | input | 5 | Low column address bits of the triggering access |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_sel | input | 2 | Read port 0 half select |
| rd0_idx | input | 3 | Read port 0 instruction index |
| rd0_data | output | 256 | Read port 0 registered vector |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_sel | input | 2 | Read port 1 half select |
| rd1_idx | input | 3 | Read port 1 instruction index |
| rd1_data | output | 256 | Read port 1 registered vector |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 2 | Write half select |
| wr_idx | input | 3 | Write instruction index |
| wr_relu | input | 1 | Clamp negative lanes to zero on write |
| wr_data | input | 256 | Write vector |

## Verification
The assertions take the select inputs as two-bit codes that are always defined. They also assume `rst` is asserted from the first edge, so the read registers start known. The hold property assumes nothing else drives the read outputs between enabled reads. The stimulus keeps every control input defined on every cycle. It changes inputs only on falling edges and returns the enables to idle between operations, so each enabled read and write is seen at exactly one rising edge.

// File: rtl/pim_rf_pkg.sv
package pim_rf_pkg;
  typedef enum logic [1:0] {
    SEL_VEC_A   = 2'd0,
    SEL_VEC_B   = 2'd1,
    SEL_SCL_ADD = 2'd2,
    SEL_SCL_MUL = 2'd3
  } half_sel_e;
endpackage

// File: rtl/pim_index_map.sv
module pim_index_map #(
  parameter int IDX_W = 3,
  parameter int COL_W = 5
) (
  input  logic             aligned,
  input  logic [1:0]       sel,
  input  logic [IDX_W-1:0] idx,
  input  logic             row_lsb,
  input  logic [COL_W-1:0] col,
  output logic [IDX_W-1:0] idx_eff
);
  import pim_rf_pkg::*;

  always_comb begin
    idx_eff = idx;
    if (aligned) begin
      unique case (half_sel_e'(sel))
        SEL_VEC_A: idx_eff = col[IDX_W-1:0];
        SEL_VEC_B: idx_eff = {row_lsb, col[2*IDX_W-2:IDX_W]};
        default:   idx_eff = idx;
      endcase
    end
  end
endmodule

// File: rtl/pim_relu_clamp.sv
module pim_relu_clamp #(
  parameter int LANES  = 16,
  parameter int LANE_W = 16
) (
  input  logic                    en,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_in;
    assign lane_in = din[l*LANE_W +: LANE_W];
    assign dout[l*LANE_W +: LANE_W] = (en && lane_in[LANE_W-1]) ? '0 : lane_in;
  end
endmodule

// File: rtl/pim_reg_bank.sv
module pim_reg_bank #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [WIDTH-1:0] ra_data,
  output logic [WIDTH-1:0] rb_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/pim_operand_rf.sv
module pim_operand_rf #(
  parameter int LANES      = 16,
  parameter int LANE_W     = 16,
  parameter int HALF_DEPTH = 8,
  parameter int COL_W      = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                aligned,
  input  logic                                row_addr_lsb,
  input  logic [COL_W-1:0]                    col_addr,
  input  logic                                rd0_en,
  input  logic [1:0]                          rd0_sel,
  input  logic [$clog2(HALF_DEPTH)-1:0]       rd0_idx,
  output logic [LANES*LANE_W-1:0]             rd0_data,
  input  logic                                rd1_en,
  input  logic [1:0]                          rd1_sel,
  input  logic [$clog2(HALF_DEPTH)-1:0]       rd1_idx,
  output logic [LANES*LANE_W-1:0]             rd1_data,
  input  logic                                wr_en,
  input  logic [1:0]                          wr_sel,
  input  logic [$clog2(HALF_DEPTH)-1:0]       wr_idx,
  input  logic                                wr_relu,
  input  logic [LANES*LANE_W-1:0]             wr_data
);
  localparam int VEC_W  = LANES * LANE_W;
  localparam int IDX_W  = $clog2(HALF_DEPTH);
  localparam int NHALF  = 4;
  localparam int NVEC   = 2;

  logic [IDX_W-1:0] rd0_ie, rd1_ie, wr_ie;
  logic [VEC_W-1:0] wr_clamped;
  logic [NHALF-1:0] bank_we;
  logic [VEC_W-1:0] bank_r0 [NHALF];
  logic [VEC_W-1:0] bank_r1 [NHALF];

  pim_index_map #(.IDX_W(IDX_W), .COL_W(COL_W)) u_map_rd0 (
    .aligned(aligned), .sel(rd0_sel), .idx(rd0_idx),
    .row_lsb(row_addr_lsb), .col(col_addr), .idx_eff(rd0_ie));
  pim_index_map #(.IDX_W(IDX_W), .COL_W(COL_W)) u_map_rd1 (
    .aligned(aligned), .sel(rd1_sel), .idx(rd1_idx),
    .row_lsb(row_addr_lsb), .col(col_addr), .idx_eff(rd1_ie));
  pim_index_map #(.IDX_W(IDX_W), .COL_W(COL_W)) u_map_wr (
    .aligned(aligned), .sel(wr_sel), .idx(wr_idx),
    .row_lsb(row_addr_lsb), .col(col_addr), .idx_eff(wr_ie));

  pim_relu_clamp #(.LANES(LANES), .LANE_W(LANE_W)) u_relu (
    .en(wr_relu), .din(wr_data), .dout(wr_clamped));

  for (genvar b = 0; b < NHALF; b++) begin : g_half
    assign bank_we[b] = wr_en && (wr_sel == 2'(b));
    if (b < NVEC) begin : g_vec
      pim_reg_bank #(.DEPTH(HALF_DEPTH), .WIDTH(VEC_W)) u_bank (
        .clk(clk), .rst(rst), .we(bank_we[b]), .widx(wr_ie), .wdata(wr_clamped),
        .ra_idx(rd0_ie), .rb_idx(rd1_ie), .ra_data(bank_r0[b]), .rb_data(bank_r1[b]));
    end else begin : g_scl
      logic [LANE_W-1:0] s0, s1;
      pim_reg_bank #(.DEPTH(HALF_DEPTH), .WIDTH(LANE_W)) u_bank (
        .clk(clk), .rst(rst), .we(bank_we[b]), .widx(wr_ie),
        .wdata(wr_clamped[LANE_W-1:0]),
        .ra_idx(rd0_ie), .rb_idx(rd1_ie), .ra_data(s0), .rb_data(s1));
      assign bank_r0[b] = {LANES{s0}};
      assign bank_r1[b] = {LANES{s1}};
    end
  end

  logic rd0_scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0_data  <= '0;
      rd1_data  <= '0;
      rd0_scl_q <= 1'b0;
    end else begin
      if (rd0_en) begin
        rd0_data  <= bank_r0[rd0_sel];
        rd0_scl_q <= rd0_sel[1];
      end
      if (rd1_en) rd1_data <= bank_r1[rd1_sel];
    end
  end

  logic [LANES-1:0] rd0_lane_eq;
  logic [LANES-1:0] clamp_sign;
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assign rd0_lane_eq[l] = rd0_data[l*LANE_W +: LANE_W] == rd0_data[LANE_W-1:0];
    assign clamp_sign[l]  = wr_clamped[l*LANE_W + LANE_W - 1];
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd0_data == '0 && rd1_data == '0));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd0_en |=> $stable(rd0_data));

  // R5
  bcast_chk: assert property (@(posedge clk) disable iff (rst)
    rd0_scl_q |-> (&rd0_lane_eq));

  // R6
  relu_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_relu) |-> (clamp_sign == '0));

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we) && (wr_en == (bank_we != '0)));
endmodule

// File: tb/tb_pim_operand_rf.sv
module tb_pim_operand_rf;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aligned = 1'b0, row_addr_lsb = 1'b0;
  logic [4:0] col_addr = '0;
  logic rd0_en = 1'b0, rd1_en = 1'b0, wr_en = 1'b0, wr_relu = 1'b0;
  logic [1:0] rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
  logic [2:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [255:0] wr_data = '0;
  logic [255:0] rd0_data, rd1_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pim_operand_rf dut (
    .clk(clk), .rst(rst), .aligned(aligned), .row_addr_lsb(row_addr_lsb),
    .col_addr(col_addr), .rd0_en(rd0_en), .rd0_sel(rd0_sel), .rd0_idx(rd0_idx),
    .rd0_data(rd0_data), .rd1_en(rd1_en), .rd1_sel(rd1_sel), .rd1_idx(rd1_idx),
    .rd1_data(rd1_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_relu(wr_relu), .wr_data(wr_data));

  // Behavioural model: lanes per half and entry.
  logic [15:0] m_lane [4][8][16];
  logic [255:0] e0 = '0, e1 = '0;
  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  function automatic int pick(int sel, int idx, bit al, int row, int col);
    if (!al || sel >= 2) return idx;
    if (sel == 0) return col % 8;
    return (row % 2) * 4 + (col / 8) % 4;
  endfunction

  function automatic logic [255:0] model_read(int sel, int e);
    logic [255:0] v;
    for (int l = 0; l < 16; l++)
      v[16*l +: 16] = (sel >= 2) ? m_lane[sel][e][0] : m_lane[sel][e][l];
    return v;
  endfunction

  function automatic logic [255:0] pat(int k);
    logic [255:0] v;
    for (int l = 0; l < 16; l++) v[16*l +: 16] = 16'(k * 40503 + l * 2749 + 17);
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int h = 0; h < 4; h++) for (int e = 0; e < 8; e++)
        for (int l = 0; l < 16; l++) m_lane[h][e][l] = 16'h0;
      e0 = '0; e1 = '0;
    end else begin
      if (rd0_en) e0 = model_read(rd0_sel, pick(rd0_sel, rd0_idx, aligned, row_addr_lsb, col_addr));
      if (rd1_en) e1 = model_read(rd1_sel, pick(rd1_sel, rd1_idx, aligned, row_addr_lsb, col_addr));
      if (wr_en) begin
        int e;
        e = pick(wr_sel, wr_idx, aligned, row_addr_lsb, col_addr);
        for (int l = 0; l < 16; l++) begin
          logic [15:0] v;
          v = wr_data[16*l +: 16];
          if (wr_relu && v[15]) v = 16'h0;
          m_lane[wr_sel][e][l] = v;
        end
      end
    end
    if (cycles > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cycles > 0) begin
      checks++;
      if (rd0_data !== e0) begin
        errors++;
        $display("FAIL %s rd0 got %h exp %h", cur_req, rd0_data, e0);
      end
      checks++;
      if (rd1_data !== e1) begin
        errors++;
        $display("FAIL %s rd1 got %h exp %h", cur_req, rd1_data, e1);
      end
    end
  end

  task automatic idle();
    rd0_en = 0; rd1_en = 0; wr_en = 0; wr_relu = 0;
  endtask

  task automatic addr(bit al, int row, int col);
    aligned = al; row_addr_lsb = row[0]; col_addr = 5'(col);
  endtask

  task automatic wr(int sel, int idx, logic [255:0] d, bit relu);
    wr_en = 1; wr_sel = 2'(sel); wr_idx = 3'(idx); wr_data = d; wr_relu = relu;
    @(negedge clk); idle();
  endtask

  task automatic rd(int s0, int i0, int s1, int i1);
    rd0_en = 1; rd0_sel = 2'(s0); rd0_idx = 3'(i0);
    rd1_en = 1; rd1_sel = 2'(s1); rd1_idx = 3'(i1);
    @(negedge clk); idle();
  endtask

  int shuf [8] = '{5, 2, 7, 0, 3, 6, 1, 4};

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: every entry reads zero after reset
    cur_req = "R1";
    for (int h = 0; h < 4; h++) for (int e = 0; e < 8; e++) rd(h, e, 3 - h, 7 - e);

    // R2 / R11: vector halves, independent ports
    cur_req = "R2";
    for (int e = 0; e < 8; e++) begin wr(0, e, pat(e), 0); wr(1, e, pat(100 + e), 0); end
    cur_req = "R11";
    for (int e = 0; e < 8; e++) rd(0, e, 1, 7 - e);

    // R5: scalar store of bits [15:0], broadcast read
    cur_req = "R5";
    for (int e = 0; e < 8; e++) begin wr(2, e, pat(200 + e), 0); wr(3, e, pat(300 + e), 0); end
    for (int e = 0; e < 8; e++) rd(2, e, 3, e);

    // R6 / R10: clamp by lane position, negative zero included
    cur_req = "R6";
    begin
      logic [255:0] d;
      logic [15:0] lv [8] = '{16'h8000, 16'hFFFF, 16'h7FFF, 16'h0001,
                              16'h0000, 16'hC000, 16'h3C00, 16'hBC00};
      for (int l = 0; l < 16; l++) d[16*l +: 16] = lv[(l * 3) % 8];
      wr(0, 3, d, 1); wr(1, 6, d, 0); wr(2, 1, d, 1); wr(3, 2, {d[255:16], 16'h8001}, 1);
      cur_req = "R10";
      rd(0, 3, 1, 6); rd(2, 1, 3, 2);
    end

    // R4: same-edge read sees old value, next read sees new
    cur_req = "R4";
    rd0_en = 1; rd0_sel = 0; rd0_idx = 4; wr(0, 4, pat(555), 0);
    rd(0, 4, 0, 4);

    // R3: hold while disabled even when entry changes
    cur_req = "R3";
    rd(1, 2, 1, 2);
    wr(1, 2, pat(777), 0);
    repeat (3) @(negedge clk);
    rd(1, 2, 0, 0);

    // R7: aligned writes to A in shuffled column order, junk instruction index
    cur_req = "R7";
    for (int k = 0; k < 8; k++) begin
      addr(1, k, shuf[k] | ((k & 3) << 3)); wr(0, 7 - shuf[k], pat(900 + shuf[k]), 0);
    end
    addr(0, 0, 0);
    for (int e = 0; e < 8; e++) rd(0, e, 0, 7 - e);
    for (int k = 0; k < 8; k++) begin addr(1, 1, shuf[7 - k]); rd(0, k, 0, 3); end

    // R8: aligned B index from row bit and column bits [4:3]
    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin
      addr(1, shuf[k] >> 2, ((shuf[k] & 3) << 3) | k); wr(1, k, pat(1200 + shuf[k]), 1);
    end
    addr(0, 0, 0);
    for (int e = 0; e < 8; e++) rd(1, e, 1, e ^ 5);

    // R9: scalar halves ignore address in aligned mode; address ignored when off
    cur_req = "R9";
    addr(1, 1, 31); wr(2, 5, pat(1500), 0); wr(3, 0, pat(1501), 0);
    rd(2, 5, 3, 0);
    addr(0, 1, 22); wr(0, 1, pat(1600), 0); rd(0, 1, 1, 1);
    addr(0, 0, 0); rd(0, 6, 0, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule